// File: doc/BRIEF.md
# Timer Compare Match Interrupt Controller

This block sits next to a free-running 64-bit system timer and watches it through two independent compare channels. Each channel selects a window of timer bits, from bit 0 up to a programmable top bit. It compares the upper part of that window against the low bits of its compare register. The lower part of the window must be all zero. When the comparison becomes true, the channel sets a sticky request flag. If the channel is enabled, it also emits a one-cycle interrupt pulse on one of two shared output lines, chosen per channel.

Software programs the block through a small synchronous write port and reads it back through a combinational read port. Flags can be forced to 1 or cleared by separate write-one strobes. A software set never causes an interrupt pulse; only hardware match events do. After reset both flags read as 1, because the reset timer value matches the reset compare values, but no pulse is produced.

Top module: `tmr_cmp_irq_ctrl`

## Requirements
- R1: For a channel with field start S (0..31) and field size Z (0..31), a match exists when timer[S+Z:S] equals compare[Z:0] and timer[S-1:0] is all zero; timer bits above S+Z and compare bits above Z are ignored.
- R2: A hardware match event sets the channel's flag on the next clock edge, whatever the channel's enable bit holds.
- R3: A match event is the rising edge of the match condition; a match held over several cycles gives one event, and a new event needs the condition to drop first.
- R4: Writing 1 to a channel's set strobe sets its flag and never pulses either interrupt output.
- R5: Writing 1 to a channel's clear strobe clears its flag; when a set (hardware event or set strobe) falls in the same cycle as a clear, the flag ends up 1.
- R6: With the enable bit at 1 an event gives a pulse of exactly one cycle, in the cycle after the event; with the enable bit at 0 it gives none.
- R7: An output-select bit of 0 sends the channel's pulse to irq_out[0], a value of 1 to irq_out[1]; each output is the OR of the pulses routed to it.
- R8: After reset both flags are 1, both outputs are 0, and all configuration registers are 0.
- R9: Register map (word addresses): 0 compare ch0, 1 compare ch1, 2 field config (ch0 start [4:0], ch0 size [12:8], ch1 start [20:16], ch1 size [28:24]), 3 control (ch0 enable bit 0, ch0 select bit 1, ch1 enable bit 4, ch1 select bit 5), 4 strobes, write-only (set0 bit 0, clr0 bit 1, set1 bit 2, clr1 bit 3), reads 0, and 5 flags, read-only, in bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_val | input | 64 | Current system timer count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| match_flag | output | 2 | Sticky request flags, one per channel |
| irq_out | output | 2 | Interrupt pulse outputs |

## Verification
A hardware match event and a software clear strobe on the same channel can land in the same clock cycle. A software set and clear on one channel can also coincide. The bench first drops a channel's match condition. It then restores the match in the very cycle it writes the channel's clear strobe. The flag must read 1 afterwards, and the routed pulse must still appear. The simultaneous set-and-clear write is judged the same way, with no pulse allowed.

// File: rtl/tcm_pkg.sv
// Package: shared constants for the timer compare interrupt controller.
// Assumes exactly two channels and two interrupt outputs.
package tcm_pkg;
    localparam int NCH      = 2;
    localparam int NOUT     = 2;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 32;
    localparam int FLD_W    = 5;

    localparam logic [ADDR_W-1:0] A_CMP0  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP1  = 3'd1;
    localparam logic [ADDR_W-1:0] A_FIELD = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STRB  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAG  = 3'd5;

    typedef struct packed {
        logic [FLD_W-1:0] start;
        logic [FLD_W-1:0] size;
        logic             en;
        logic             osel;
    } chan_cfg_t;
endpackage

// File: rtl/tcm_regs.sv
// Module: configuration register file and read mux.
// Holds per-channel compare values and settings; decodes write-one
// strobes into single-cycle set/clear pulses. Read data is combinational.
module tcm_regs
    import tcm_pkg::*;
#(
    parameter int CMP_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [NCH-1:0]             flags,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NCH-1:0][CMP_W-1:0]  cmp_val,
    output chan_cfg_t [NCH-1:0]        cfg,
    output logic [NCH-1:0]             set_stb,
    output logic [NCH-1:0]             clr_stb
);
    // Compare value registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_val <= '0;
        end else if (wr_en && wr_addr == A_CMP0) begin
            cmp_val[0] <= wr_data[CMP_W-1:0];
        end else if (wr_en && wr_addr == A_CMP1) begin
            cmp_val[1] <= wr_data[CMP_W-1:0];
        end
    end

    // Field and control registers, one slice per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[c] <= '0;
            end else if (wr_en) begin
                if (wr_addr == A_FIELD) begin
                    cfg[c].start <= wr_data[16*c +: FLD_W];
                    cfg[c].size  <= wr_data[16*c + 8 +: FLD_W];
                end
                if (wr_addr == A_CTRL) begin
                    cfg[c].en   <= wr_data[4*c];
                    cfg[c].osel <= wr_data[4*c + 1];
                end
            end
        end

        // Strobe decode: pulses exist only in the write cycle.
        always_comb begin
            set_stb[c] = wr_en && (wr_addr == A_STRB) && wr_data[2*c];
            clr_stb[c] = wr_en && (wr_addr == A_STRB) && wr_data[2*c + 1];
        end
    end

    // Read mux; strobe address always returns zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CMP0:  rd_data[CMP_W-1:0] = cmp_val[0];
            A_CMP1:  rd_data[CMP_W-1:0] = cmp_val[1];
            A_FIELD: begin
                for (int c = 0; c < NCH; c++) begin
                    rd_data[16*c +: FLD_W]     = cfg[c].start;
                    rd_data[16*c + 8 +: FLD_W] = cfg[c].size;
                end
            end
            A_CTRL: begin
                for (int c = 0; c < NCH; c++) begin
                    rd_data[4*c]     = cfg[c].en;
                    rd_data[4*c + 1] = cfg[c].osel;
                end
            end
            A_FLAG:  rd_data[NCH-1:0] = flags;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tcm_field_cmp.sv
// Module: bit-field comparator for one channel.
// Compares timer[start+size:0] against compare[size:0] shifted left by
// start, i.e. the compare value right-extended with start zero bits.
// Assumes start+size fits inside the timer width.
module tcm_field_cmp
    import tcm_pkg::*;
#(
    parameter int TMR_W = 64,
    parameter int CMP_W = 32
) (
    input  logic [TMR_W-1:0]  timer_val,
    input  logic [CMP_W-1:0]  cmp_val,
    input  logic [FLD_W-1:0]  start,
    input  logic [FLD_W-1:0]  size,
    output logic              eq
);
    localparam int SH_W = $clog2(TMR_W) + 1;

    logic [SH_W-1:0]  top_bit;
    logic [SH_W-1:0]  win_shr;
    logic [SH_W-1:0]  len_shr;
    logic [TMR_W-1:0] win_mask;
    logic [TMR_W-1:0] len_mask;
    logic [TMR_W-1:0] target;

    // Build the window mask and the zero-extended, shifted compare value.
    always_comb begin
        top_bit  = SH_W'(start) + SH_W'(size);
        win_shr  = SH_W'(TMR_W - 1) - top_bit;
        len_shr  = SH_W'(TMR_W - 1) - SH_W'(size);
        win_mask = {TMR_W{1'b1}} >> win_shr;
        len_mask = {TMR_W{1'b1}} >> len_shr;
        target   = (TMR_W'(cmp_val) & len_mask) << start;
        eq       = ((timer_val & win_mask) == target);
    end
endmodule

// File: rtl/tcm_chan_flag.sv
// Module: edge detector and sticky request flag for one channel.
// The equality history resets to 1 so the reset-time match yields no
// event; the flag itself resets to 1. Any set beats a clear.
module tcm_chan_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic eq,
    input  logic set_stb,
    input  logic clr_stb,
    output logic evt,
    output logic flag
);
    logic eq_q;

    // Remember last cycle's equality.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b1;
        else        eq_q <= eq;
    end

    // Event is the rising edge of equality.
    always_comb evt = eq && !eq_q;

    // Sticky flag: set by event or strobe, cleared by strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag <= 1'b1;
        else if (evt || set_stb)   flag <= 1'b1;
        else if (clr_stb)          flag <= 1'b0;
    end
endmodule

// File: rtl/tcm_irq_route.sv
// Module: gates channel events by enable and steers them to outputs.
// Each output is the registered OR of the events selecting it.
module tcm_irq_route
    import tcm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      evt,
    input  chan_cfg_t [NCH-1:0] cfg,
    output logic [NOUT-1:0]     irq_out
);
    logic [NOUT-1:0] irq_d;

    // OR together enabled events per output line.
    always_comb begin
        irq_d = '0;
        for (int c = 0; c < NCH; c++) begin
            if (evt[c] && cfg[c].en) irq_d[cfg[c].osel] = 1'b1;
        end
    end

    // Register outputs to form clean one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= irq_d;
    end
endmodule

// File: rtl/tmr_cmp_irq_ctrl.sv
// Module: top of the timer compare match interrupt controller.
// Two channels compare timer bit-fields; matches set flags and, when
// enabled, pulse one of two outputs. Synchronous active-low reset.
module tmr_cmp_irq_ctrl
    import tcm_pkg::*;
#(
    parameter int TMR_W = 64,
    parameter int CMP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  timer_val,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    match_flag,
    output logic [NOUT-1:0]   irq_out
);
    logic [NCH-1:0][CMP_W-1:0] cmp_val;
    chan_cfg_t [NCH-1:0]       cfg;
    logic [NCH-1:0]            set_stb;
    logic [NCH-1:0]            clr_stb;
    logic [NCH-1:0]            eq;
    logic [NCH-1:0]            match_evt;

    tcm_regs #(.CMP_W(CMP_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .flags(match_flag), .rd_data(rd_data),
        .cmp_val(cmp_val), .cfg(cfg),
        .set_stb(set_stb), .clr_stb(clr_stb)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tcm_field_cmp #(.TMR_W(TMR_W), .CMP_W(CMP_W)) u_cmp (
            .timer_val(timer_val), .cmp_val(cmp_val[c]),
            .start(cfg[c].start), .size(cfg[c].size), .eq(eq[c])
        );
        tcm_chan_flag u_flag (
            .clk(clk), .rst_n(rst_n), .eq(eq[c]),
            .set_stb(set_stb[c]), .clr_stb(clr_stb[c]),
            .evt(match_evt[c]), .flag(match_flag[c])
        );
    end

    tcm_irq_route u_route (
        .clk(clk), .rst_n(rst_n), .evt(match_evt), .cfg(cfg),
        .irq_out(irq_out)
    );
endmodule

// File: rtl/tcm_checker.sv
// Checker: temporal properties of the controller, bound to the top.
module tcm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] evt,
    input logic [1:0] set_stb,
    input logic [1:0] clr_stb,
    input logic [1:0] flag,
    input logic [1:0] irq_out,
    input logic [1:0] en,
    input logic [1:0] osel,
    input logic [2:0] rd_addr,
    input logic [31:0] rd_data
);
    AST_EVT0_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        evt[0] |=> flag[0]); // R2
    AST_EVT1_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        evt[1] |=> flag[1]); // R2
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt[0] |=> !evt[0]); // R3
    AST_NO_IRQ_WITHOUT_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == 2'b00) |=> (irq_out == 2'b00)); // R4
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb[0] && !set_stb[0] && !evt[0]) |=> !flag[0]); // R5
    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[1] && !en[1] && !(evt[0] && en[0])) |=> (irq_out == 2'b00)); // R6
    AST_ROUTE_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[0] && en[0] && !osel[0]) |=> irq_out[0]); // R7
    AST_STRB_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 3'd4) |-> (rd_data == 32'd0)); // R9
endmodule

bind tmr_cmp_irq_ctrl tcm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .evt(match_evt),
    .set_stb(set_stb), .clr_stb(clr_stb), .flag(match_flag),
    .irq_out(irq_out), .en({cfg[1].en, cfg[0].en}),
    .osel({cfg[1].osel, cfg[0].osel}),
    .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_tmr_cmp_irq_ctrl.sv
module sim_tmr_cmp_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] timer_val = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  match_flag;
    logic [1:0]  irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] flag;
        logic [1:0] irq;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    tmr_cmp_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .match_flag(match_flag), .irq_out(irq_out)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the result expected
    // after the next rising edge.
    task automatic cyc(input logic [63:0] t, input logic we,
                       input logic [2:0] wa, input logic [31:0] wd,
                       input logic [1:0] ef, input logic [1:0] ei,
                       input string tag);
        exp_t e;
        @(negedge clk);
        timer_val = t;
        wr_en = we;
        wr_addr = wa;
        wr_data = wd;
        e.flag = ef;
        e.irq = ei;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: after each edge compare outputs with the queued item.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({30'd0, match_flag}, {30'd0, e.flag}, {e.tag, " flag"});
                check({30'd0, irq_out}, {30'd0, e.irq}, {e.tag, " irq"});
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: reset state
        check({30'd0, match_flag}, 32'd3, "R8 reset flags");
        check({30'd0, irq_out}, 32'd0, "R8 reset irq");
        rd_addr = 3'd2; #1;
        check(rd_data, 32'd0, "R8 reset field cfg");
        rd_addr = 3'd3; #1;
        check(rd_data, 32'd0, "R8 reset ctrl");

        cyc(64'h5, 0, 0, 0, 2'b11, 2'b00, "R8 idle after reset");
        cyc(64'h5, 1, 3'd4, 32'hA, 2'b00, 2'b00, "R5 clear both");
        cyc(64'h1, 1, 3'd2, 32'h07080304, 2'b00, 2'b00, "R9 field write");
        cyc(64'h1, 1, 3'd0, 32'hA, 2'b00, 2'b00, "R9 cmp0 write");
        cyc(64'h1, 1, 3'd1, 32'h5C, 2'b00, 2'b00, "R9 cmp1 write");
        cyc(64'h1, 1, 3'd3, 32'h31, 2'b00, 2'b00, "R9 ctrl write");
        // R1 match ignoring upper bits; R6/R7 pulse to out0
        cyc(64'h1A0, 0, 0, 0, 2'b01, 2'b01, "R1 ch0 match");
        cyc(64'h1A0, 0, 0, 0, 2'b01, 2'b00, "R3 held match no repeat");
        cyc(64'hA8, 1, 3'd4, 32'h2, 2'b00, 2'b00, "R1 low bits nonzero");
        cyc(64'hA8, 0, 0, 0, 2'b00, 2'b00, "R1 no match low bits");
        cyc(64'h2A0, 0, 0, 0, 2'b01, 2'b01, "R3 re-armed event");
        cyc(64'h5C00, 0, 0, 0, 2'b11, 2'b10, "R7 ch1 to out1");
        cyc(64'h5C00, 1, 3'd4, 32'hA, 2'b00, 2'b00, "R5 clear all");
        cyc(64'h5C01, 0, 0, 0, 2'b00, 2'b00, "R1 ch1 mismatch");
        cyc(64'h5C00, 1, 3'd4, 32'h8, 2'b10, 2'b10, "R5 event beats clear");
        cyc(64'h5C00, 1, 3'd4, 32'h1, 2'b11, 2'b00, "R4 sw set no irq");
        cyc(64'h5C00, 1, 3'd3, 32'h20, 2'b11, 2'b00, "R6 disable");
        cyc(64'h5C00, 1, 3'd4, 32'hA, 2'b00, 2'b00, "R5 clear all again");
        cyc(64'h5C01, 0, 0, 0, 2'b00, 2'b00, "R3 drop condition");
        cyc(64'h5C00, 0, 0, 0, 2'b10, 2'b00, "R2 flag without enable");
        cyc(64'h5C01, 1, 3'd3, 32'h11, 2'b10, 2'b00, "R7 both to out0");
        cyc(64'h5C01, 1, 3'd0, 32'h0, 2'b10, 2'b00, "R9 cmp0 zero");
        cyc(64'h5C01, 1, 3'd4, 32'hA, 2'b00, 2'b00, "R5 clear before OR");
        cyc(64'h5C00, 0, 0, 0, 2'b11, 2'b01, "R7 OR of two channels");
        cyc(64'h5C00, 1, 3'd4, 32'h2, 2'b10, 2'b00, "R5 clear ch0");
        cyc(64'h5C00, 1, 3'd4, 32'h3, 2'b11, 2'b00, "R5 set beats clear");
        cyc(64'h5C00, 0, 0, 0, 2'b11, 2'b00, "R6 pulse ended");
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        // R9 readback
        rd_addr = 3'd1; #1;
        check(rd_data, 32'h5C, "R9 cmp1 read");
        rd_addr = 3'd2; #1;
        check(rd_data, 32'h07080304, "R9 field read");
        rd_addr = 3'd3; #1;
        check(rd_data, 32'h11, "R9 ctrl read");
        rd_addr = 3'd4; #1;
        check(rd_data, 32'h0, "R9 strobe reads zero");
        rd_addr = 3'd5; #1;
        check(rd_data, 32'h3, "R9 flag read");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule